// File: doc/BRIEF.md
# Reset-Source and Voltage-Monitor Status Register

This block is an 8-bit control and status register on a simple memory-mapped bus. It keeps two flags that record why the chip last came out of reset: a watchdog timeout, a low-voltage trip, or the external reset pin. It also shows two live hardware levels, PLL lock and a low-supply comparison from an analog voltage detector. When the detector starts reporting a low supply and software has enabled it, the block raises an interrupt request.

Each flag has its own clearing rule. The low-voltage flag clears when software reads the register. It is not touched by a later watchdog or pin reset, so the first failure stays on record. The watchdog flag clears when software writes a zero to its bit, and also when a low-voltage reset occurs. The interrupt stays pending until the CPU acknowledges entry into the service routine. The PLL and detector levels pass through a synchronizer of `SYNC_STAGES` flops before they become visible.

Software decodes the reset cause from the two flags as follows:
- Low-voltage flag 1: a low-voltage reset, whatever the watchdog flag holds.
- Low-voltage flag 0, watchdog flag 1: a watchdog reset.
- Both flags 0: a pin reset.

Top module: `rsr_status_reg`

## Requirements
- R1: Bits 7 to 5 always read as zero. Writing ones to them has no visible effect.
- R2: Bit 4 (watchdog flag) is set by a watchdog reset event. A bus write with bit 4 at 0 clears it. A write with bit 4 at 1 leaves it unchanged.
- R3: A low-voltage reset event sets bit 2 (low-voltage flag) and clears bit 4 in the same update.
- R4: A watchdog or pin reset event leaves bit 2 unchanged. A pin reset event clears bit 4, so that with bit 2 at 0 both flags read 0.
- R5: A bus read returns bit 2 as it currently stands. The flag reads as 0 from the next cycle on.
- R6: Bit 3 shows `pll_lock` delayed by `SYNC_STAGES` clocks, and bus writes do not change it.
- R7: Bit 1 shows `vdet_low` delayed by `SYNC_STAGES` clocks, and bus writes do not change it.
- R8: Bit 0 (interrupt enable) is written and read by software. Any reset event clears it.
- R9: An interrupt becomes pending in the cycle that bit 1 changes from 0 to 1 while bit 0 is 1. `irq` is high while an interrupt is pending and bit 0 is 1.
- R10: A one-cycle `irq_ack` clears the pending interrupt. A new 0-to-1 change of bit 1 in the same cycle keeps it pending.
- R11: Any reset event clears the pending interrupt. A bus read or write in the same cycle as a reset event is ignored.
- R12: `rdata` is all zero unless `sel` and `rd_en` are both high.
- R13: While `por_n` is low, every flag, the enable, the pending interrupt and the synchronizers clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, synchronous |
| sel | input | 1 | Register select from the address decoder |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not reading |
| wdg_rst_evt | input | 1 | One-cycle watchdog reset event |
| lvd_rst_evt | input | 1 | One-cycle low-voltage reset event |
| ext_rst_evt | input | 1 | One-cycle reset-pin event |
| pll_lock | input | 1 | PLL lock level |
| vdet_low | input | 1 | Voltage detector level, 1 means supply below threshold |
| irq_ack | input | 1 | One-cycle pulse when the service routine is entered |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the reset event lines and `irq_ack` are single-cycle pulses sampled on `clk`. They also assume that the bus strobes are only acted on while `sel` is high. The bench drives every input on the falling edge, so each input is stable for a full cycle before the rising edge that samples it. Events, reads and writes are raised for exactly one cycle, both in the directed phases and in the randomized phase. That phase also collides reset events with bus accesses and acknowledges on purpose, to exercise the precedence rules.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    // Bit positions in the register image; software decodes these.
    localparam int unsigned BIT_IE   = 0;
    localparam int unsigned BIT_VDET = 1;
    localparam int unsigned BIT_LVD  = 2;
    localparam int unsigned BIT_LOCK = 3;
    localparam int unsigned BIT_WDG  = 4;
    localparam int unsigned USED_BITS = 5;

    typedef struct packed {
        logic wdg;
        logic lvd;
        logic ie;
        logic pend;
    } rsr_state_t;
endpackage

// File: rtl/rsr_bus_decode.sv
module rsr_bus_decode
    import rsr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              wr_ie,
    output logic              wr_wdg_zero
);
    always_comb begin
        rd_strobe   = sel & rd_en;
        wr_strobe   = sel & wr_en;
        wr_ie       = wdata[BIT_IE];
        wr_wdg_zero = ~wdata[BIT_WDG];
    end
endmodule

// File: rtl/rsr_level_sync.sv
module rsr_level_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic level_in,
    output logic level_q,
    output logic level_next
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = level_in;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], level_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!por_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign level_q    = stage_q[STAGES-1];
    assign level_next = por_n & stage_d[STAGES-1];
endmodule

// File: rtl/rsr_flags.sv
module rsr_flags
    import rsr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic lvd_evt,
    input  logic wdg_evt,
    input  logic ext_evt,
    input  logic rd_strobe,
    input  logic wr_strobe,
    input  logic wr_ie,
    input  logic wr_wdg_zero,
    input  logic vdet_q,
    input  logic vdet_next,
    input  logic irq_ack,
    output logic wdg_flag,
    output logic lvd_flag,
    output logic ie_flag,
    output logic irq
);
    rsr_state_t st_d, st_q;
    logic any_evt;
    logic vdet_rise;

    always_comb begin
        any_evt   = lvd_evt | wdg_evt | ext_evt;
        vdet_rise = vdet_next & ~vdet_q;
        st_d      = st_q;
        if (any_evt) begin
            // Reset events outrank every bus access in the same cycle.
            st_d.ie   = 1'b0;
            st_d.pend = 1'b0;
            if (lvd_evt) begin
                st_d.lvd = 1'b1;
                st_d.wdg = 1'b0;
            end else if (wdg_evt) begin
                st_d.wdg = 1'b1;
            end else begin
                st_d.wdg = 1'b0;
            end
        end else begin
            if (rd_strobe) st_d.lvd = 1'b0;
            if (wr_strobe) begin
                st_d.ie = wr_ie;
                if (wr_wdg_zero) st_d.wdg = 1'b0;
            end
            if (vdet_rise && st_q.ie) st_d.pend = 1'b1;
            else if (irq_ack)         st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdg_flag = st_q.wdg;
    assign lvd_flag = st_q.lvd;
    assign ie_flag  = st_q.ie;
    assign irq      = st_q.pend & st_q.ie;
endmodule

// File: rtl/rsr_status_reg.sv
module rsr_status_reg
    import rsr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wdg_rst_evt,
    input  logic              lvd_rst_evt,
    input  logic              ext_rst_evt,
    input  logic              pll_lock,
    input  logic              vdet_low,
    input  logic              irq_ack,
    output logic              irq
);
    logic rd_strobe, wr_strobe, wr_ie, wr_wdg_zero;
    logic lock_flag, lock_next;
    logic vdet_flag, vdet_next;
    logic wdg_flag, lvd_flag, ie_flag;

    rsr_bus_decode #(.DATA_W(DATA_W)) u_dec (
        .sel(sel), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .wr_ie(wr_ie), .wr_wdg_zero(wr_wdg_zero)
    );

    rsr_level_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk(clk), .por_n(por_n), .level_in(pll_lock),
        .level_q(lock_flag), .level_next(lock_next)
    );

    rsr_level_sync #(.STAGES(SYNC_STAGES)) u_vdet_sync (
        .clk(clk), .por_n(por_n), .level_in(vdet_low),
        .level_q(vdet_flag), .level_next(vdet_next)
    );

    rsr_flags u_flags (
        .clk(clk), .por_n(por_n),
        .lvd_evt(lvd_rst_evt), .wdg_evt(wdg_rst_evt), .ext_evt(ext_rst_evt),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .wr_ie(wr_ie), .wr_wdg_zero(wr_wdg_zero),
        .vdet_q(vdet_flag), .vdet_next(vdet_next), .irq_ack(irq_ack),
        .wdg_flag(wdg_flag), .lvd_flag(lvd_flag), .ie_flag(ie_flag),
        .irq(irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_strobe) begin
            rdata[BIT_WDG]  = wdg_flag;
            rdata[BIT_LOCK] = lock_flag;
            rdata[BIT_LVD]  = lvd_flag;
            rdata[BIT_VDET] = vdet_flag;
            rdata[BIT_IE]   = ie_flag;
        end
    end
endmodule

// File: rtl/rsr_status_reg_chk.sv
module rsr_status_reg_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              sel,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              wdg_rst_evt,
    input logic              lvd_rst_evt,
    input logic              ext_rst_evt,
    input logic              irq_ack,
    input logic              irq,
    input logic              wdg_flag,
    input logic              lvd_flag,
    input logic              vdet_flag
);
    logic any_evt;
    assign any_evt = wdg_rst_evt | lvd_rst_evt | ext_rst_evt;

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
        rdata[DATA_W-1:5] == '0);

    p_wdg_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdg_rst_evt && !lvd_rst_evt |=> wdg_flag);

    p_lvd_sets_r3: assert property (@(posedge clk) disable iff (!por_n)
        lvd_rst_evt |=> lvd_flag && !wdg_flag);

    p_lvd_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
        lvd_flag && !(sel && rd_en) |=> lvd_flag);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
        sel && rd_en && !any_evt |=> !lvd_flag);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!por_n)
        irq_ack && vdet_flag |=> !irq);

    p_evt_clears_irq_r11: assert property (@(posedge clk) disable iff (!por_n)
        any_evt |=> !irq);

    p_idle_bus_zero_r12: assert property (@(posedge clk) disable iff (!por_n)
        !(sel && rd_en) |-> rdata == '0);
endmodule

bind rsr_status_reg rsr_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .por_n(por_n), .sel(sel), .rd_en(rd_en), .rdata(rdata),
    .wdg_rst_evt(wdg_rst_evt), .lvd_rst_evt(lvd_rst_evt),
    .ext_rst_evt(ext_rst_evt), .irq_ack(irq_ack), .irq(irq),
    .wdg_flag(wdg_flag), .lvd_flag(lvd_flag), .vdet_flag(vdet_flag)
);

// File: tb/rsr_status_reg_test.sv
module rsr_status_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sel = 0, rd_en = 0, wr_en = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wdg_rst_evt = 0, lvd_rst_evt = 0, ext_rst_evt = 0;
    logic       pll_lock = 0, vdet_low = 0, irq_ack = 0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Behavioural reference state
    bit m_wdg, m_lvd, m_ie, m_pend;
    bit vq[$];
    bit lq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rsr_status_reg #(.DATA_W(8), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .por_n(por_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .wdg_rst_evt(wdg_rst_evt),
        .lvd_rst_evt(lvd_rst_evt), .ext_rst_evt(ext_rst_evt),
        .pll_lock(pll_lock), .vdet_low(vdet_low), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic model_clear();
        m_wdg = 0; m_lvd = 0; m_ie = 0; m_pend = 0;
        vq.delete(); lq.delete();
        for (int i = 0; i < SYNC; i++) begin vq.push_back(1'b0); lq.push_back(1'b0); end
    endtask

    function automatic logic [7:0] exp_rdata();
        logic [7:0] v = 8'h00;
        if (sel && rd_en) v = {3'b000, m_wdg, lq[0], m_lvd, vq[0], m_ie};
        return v;
    endfunction

    task automatic check(input string tag);
        logic [7:0] er = exp_rdata();
        logic ei = m_pend & m_ie;
        n_checks++;
        if (rdata !== er) begin
            n_fail++;
            $display("FAIL %s rdata actual=%02h expected=%02h t=%0t", tag, rdata, er, $time);
        end
        n_checks++;
        if (irq !== ei) begin
            n_fail++;
            $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, ei, $time);
        end
    endtask

    task automatic model_step();
        bit old_v, new_v, any;
        if (!por_n) begin model_clear(); return; end
        old_v = vq[0];
        void'(vq.pop_front()); vq.push_back(vdet_low);
        void'(lq.pop_front()); lq.push_back(pll_lock);
        new_v = vq[0];
        any = wdg_rst_evt | lvd_rst_evt | ext_rst_evt;
        if (any) begin
            m_ie = 0; m_pend = 0;
            if (lvd_rst_evt) begin m_lvd = 1; m_wdg = 0; end
            else if (wdg_rst_evt) m_wdg = 1;
            else m_wdg = 0;
        end else begin
            bit old_ie = m_ie;
            if (sel && rd_en) m_lvd = 0;
            if (sel && wr_en) begin
                m_ie = wdata[0];
                if (!wdata[4]) m_wdg = 0;
            end
            if (new_v && !old_v && old_ie) m_pend = 1;
            else if (irq_ack) m_pend = 0;
        end
    endtask

    // Inputs are set at the falling edge; outputs checked 1 time unit later.
    task automatic cyc(input string tag);
        #1 check(tag);
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        sel = 0; rd_en = 0; wr_en = 0; wdata = 8'h00;
        wdg_rst_evt = 0; lvd_rst_evt = 0; ext_rst_evt = 0; irq_ack = 0;
    endtask

    task automatic rd(input string tag);
        sel = 1; rd_en = 1; cyc(tag);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        sel = 1; wr_en = 1; wdata = d; cyc(tag);
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        // R13: power-on clear
        cyc("R13"); cyc("R13");
        sel = 1; rd_en = 1; cyc("R13");
        por_n = 1;
        rd("R13"); rd("R12");
        sel = 1; cyc("R12");                 // selected, no strobe
        rd_en = 1; cyc("R12");               // strobe, not selected
        // R6, R7: synchronized levels
        pll_lock = 1; vdet_low = 1;
        rd("R6"); rd("R7"); rd("R6");
        wr(8'h00, "R7");                     // read-only bits ignore writes
        rd("R7");
        vdet_low = 0; cyc("R7"); cyc("R7"); rd("R7");
        // R1, R8: enable write with all ones
        wr(8'hFF, "R1"); rd("R1"); rd("R8");
        // R9: rising detector edge raises irq
        vdet_low = 1; cyc("R9"); cyc("R9"); cyc("R9"); rd("R9");
        // R10: acknowledge
        irq_ack = 1; cyc("R10"); cyc("R10");
        wr(8'h00, "R9"); vdet_low = 0; cyc("R9"); cyc("R9");
        wr(8'h01, "R9"); vdet_low = 1; cyc("R9"); cyc("R9"); cyc("R9");
        // R10: ack in the cycle of a new rising edge keeps it pending
        vdet_low = 0; cyc("R10"); cyc("R10"); cyc("R10");
        vdet_low = 1; cyc("R10"); irq_ack = 1; cyc("R10"); cyc("R10");
        // R2: watchdog flag
        wdg_rst_evt = 1; cyc("R2"); rd("R2");
        wr(8'h11, "R2"); rd("R2");
        wr(8'h01, "R2"); rd("R2");
        // R3: low-voltage event after watchdog
        wdg_rst_evt = 1; cyc("R3"); lvd_rst_evt = 1; cyc("R3"); cyc("R3");
        // R5: read returns set value then clears
        rd("R5"); rd("R5");
        // R4: sticky across watchdog and pin resets
        lvd_rst_evt = 1; cyc("R4"); wdg_rst_evt = 1; cyc("R4");
        ext_rst_evt = 1; cyc("R4"); rd("R4"); rd("R4");
        wdg_rst_evt = 1; cyc("R4"); ext_rst_evt = 1; cyc("R4"); rd("R4");
        // R11: reset event clears pending, bus access in same cycle ignored
        vdet_low = 0; wr(8'h01, "R11"); cyc("R11"); cyc("R11");
        vdet_low = 1; cyc("R11"); cyc("R11"); cyc("R11");
        lvd_rst_evt = 1; cyc("R11"); cyc("R11");
        sel = 1; rd_en = 1; wr_en = 1; wdata = 8'h01; wdg_rst_evt = 1; cyc("R11");
        rd("R11"); rd("R11");
        // Randomized phase
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 15);
            sel = ($urandom_range(0, 3) != 0);
            rd_en = $urandom_range(0, 1);
            wr_en = $urandom_range(0, 2) == 0;
            wdata = 8'($urandom);
            wdg_rst_evt = (r == 1);
            lvd_rst_evt = (r == 2);
            ext_rst_evt = (r == 3) || (r == 4 && i[0]);
            irq_ack = $urandom_range(0, 3) == 0;
            if ($urandom_range(0, 4) == 0) vdet_low = ~vdet_low;
            if ($urandom_range(0, 6) == 0) pll_lock = ~pll_lock;
            cyc("R9");
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule